// File: doc/BRIEF.md
# Multiplexed Bus Cycle Monitor

This block sits beside an 8-bit processor whose low address byte and data byte share one set of pins. It drives nothing. Each clock it samples the bus, where one clock equals one T state. From these samples it rebuilds each machine cycle: the full 16-bit address, the cycle type, the data byte moved, and the number of T states the cycle lasted.

A cycle starts when the address strobe rises. It can also start when the three status pins change value while the address strobe stays low; this is how a bus idle cycle is found. A cycle ends when the next one starts. At that point a record of the finished cycle is presented for one clock. The record carries three flags:
- an illegal-length flag;
- a flag for an IO cycle whose two address halves disagree;
- a flag for a cycle in which no strobe was ever seen.

Top module: `bus_cycle_monitor`

## Requirements
- R1: During reset and after it, every output is 0 until the first record is produced.
- R2: While `ale` is sampled high, the low address byte is taken from `ad` and the high byte from `a_hi`. The value from the last such sample is reported as `rec_addr = {a_hi, ad}`.
- R3: `rec_kind` is decoded from `{io_m, st}` as sampled at the cycle's first clock. The codes are: 011 opcode fetch -> 0, 010 memory read -> 1, 001 memory write -> 2, 110 IO read -> 3, 101 IO write -> 4, 111 interrupt acknowledge -> 5, 000 bus idle -> 6, 100 -> 7 (undefined).
- R4: `rec_tcount` is the number of clocks from a cycle's first clock up to, but not including, the first clock of the next cycle.
- R5: `rec_data` is the value of `ad` at the last clock of the cycle in which any of `rd_n`, `wr_n` or `inta_n` was low.
- R6: A cycle begins on a clock where `ale` is high after being low on the previous clock. When the next cycle begins, `rec_valid` is high for the clock that follows, and the other outputs hold the finished cycle's record. No record is produced for the clocks before the first cycle.
- R7: A cycle also begins when `ale` is low and `{io_m, st}` differs from the status of the current cycle. Before the first cycle, that status counts as 000. A cycle in which `ale` is never high reports address 0.
- R8: `rec_len_err` is 1 when the length is illegal for the type. The legal lengths are:
  - opcode fetch: 4 or 6;
  - memory and IO read/write: 3;
  - bus idle: 6;
  - code 7: no length is legal.
- R9: An interrupt acknowledge cycle must last 6 T states, unless the cycle before it was also an interrupt acknowledge; in that case it must last 3.
- R10: `rec_port_mismatch` is 1 only for IO read or IO write cycles whose high and low address bytes differ.
- R11: `rec_no_data` is 1, and `rec_data` is 0, when no strobe was low during the cycle.
- R12: `rec_tcount` saturates at its maximum value (15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, one T state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe: shared pins carry the low address |
| ad | input | 8 | Shared low-address/data pins |
| a_hi | input | 8 | High address pins |
| io_m | input | 1 | 1 = IO space, 0 = memory |
| st | input | 2 | Status pins (read/write/fetch) |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt acknowledge strobe, active low |
| rec_valid | output | 1 | One-clock record strobe |
| rec_kind | output | 3 | Cycle type code |
| rec_addr | output | 16 | Full address |
| rec_data | output | 8 | Data byte captured at strobe end |
| rec_tcount | output | TW | T states the cycle lasted |
| rec_len_err | output | 1 | Length illegal for the type |
| rec_port_mismatch | output | 1 | IO address halves differ |
| rec_no_data | output | 1 | No strobe was seen |

## Verification
The bench covers several corner cases, each of which a wrong design would get visibly wrong:
- A bus idle cycle that follows a fetch and has no address strobe. A design that waits only for the address strobe would merge it into the fetch and report a 10-state fetch.
- A chain of acknowledge cycles (6, 3, 3) followed by a lone 3-state acknowledge. A design without memory of the previous cycle type would flag the chain or miss the lone error.
- A read with no strobe, and a 20-clock idle stretch. These catch data left over from the previous cycle and a counter that wraps instead of saturating.
- IO cycles with equal and with unequal address halves.
- Data that changes after the strobe rises. This exposes a design that captures data at the end of the cycle rather than at the end of the strobe.

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [7:0]    ad,
  input  logic [7:0]    a_hi,
  input  logic          io_m,
  input  logic [1:0]    st,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          inta_n,
  output logic          rec_valid,
  output logic [2:0]    rec_kind,
  output logic [15:0]   rec_addr,
  output logic [7:0]    rec_data,
  output logic [TW-1:0] rec_tcount,
  output logic          rec_len_err,
  output logic          rec_port_mismatch,
  output logic          rec_no_data
);

  localparam logic [2:0] K_FETCH = 3'd0, K_MRD = 3'd1, K_MWR = 3'd2, K_IORD = 3'd3,
                         K_IOWR  = 3'd4, K_INTA = 3'd5, K_IDLE = 3'd6, K_BAD = 3'd7;
  localparam logic [TW-1:0] T_MAX = {TW{1'b1}};
  localparam logic [TW-1:0] T3 = TW'(3), T4 = TW'(4), T6 = TW'(6);

  logic          ale_q, run, prev_inta, got;
  logic [2:0]    cur_stat, cur_kind;
  logic [7:0]    lo, hi, dat;
  logic [TW-1:0] tcnt;

  wire [2:0] stat_in = {io_m, st};
  wire strobe = !rd_n || !wr_n || !inta_n;
  wire begin_c = (ale && !ale_q) || (!ale && stat_in != cur_stat);

  function automatic logic [2:0] decode(input logic [2:0] s);
    case (s)
      3'b011:  return K_FETCH;
      3'b010:  return K_MRD;
      3'b001:  return K_MWR;
      3'b110:  return K_IORD;
      3'b101:  return K_IOWR;
      3'b111:  return K_INTA;
      3'b000:  return K_IDLE;
      default: return K_BAD;
    endcase
  endfunction

  function automatic logic legal(input logic [2:0] k, input logic [TW-1:0] t, input logic pi);
    case (k)
      K_FETCH:                     return t == T4 || t == T6;
      K_MRD, K_MWR, K_IORD, K_IOWR: return t == T3;
      K_INTA:                      return pi ? (t == T3) : (t == T6);
      K_IDLE:                      return t == T6;
      default:                     return 1'b0;
    endcase
  endfunction

  wire is_io = cur_kind == K_IORD || cur_kind == K_IOWR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q <= 1'b0; run <= 1'b0; prev_inta <= 1'b0; got <= 1'b0;
      cur_stat <= 3'b000; cur_kind <= K_IDLE;
      lo <= '0; hi <= '0; dat <= '0; tcnt <= '0;
      rec_valid <= 1'b0; rec_kind <= '0; rec_addr <= '0; rec_data <= '0;
      rec_tcount <= '0; rec_len_err <= 1'b0; rec_port_mismatch <= 1'b0; rec_no_data <= 1'b0;
    end else begin
      ale_q <= ale;
      rec_valid <= begin_c && run;
      if (begin_c) begin
        if (run) begin
          rec_kind          <= cur_kind;
          rec_addr          <= {hi, lo};
          rec_data          <= got ? dat : 8'h00;
          rec_tcount        <= tcnt;
          rec_len_err       <= !legal(cur_kind, tcnt, prev_inta);
          rec_port_mismatch <= is_io && (hi != lo);
          rec_no_data       <= !got;
        end
        prev_inta <= run && cur_kind == K_INTA;
        run       <= 1'b1;
        cur_stat  <= stat_in;
        cur_kind  <= decode(stat_in);
        tcnt      <= TW'(1);
        lo        <= ale ? ad : 8'h00;
        hi        <= ale ? a_hi : 8'h00;
        got       <= strobe;
        dat       <= strobe ? ad : 8'h00;
      end else if (run) begin
        if (tcnt != T_MAX) tcnt <= tcnt + TW'(1);
        if (ale) begin
          lo <= ad;
          hi <= a_hi;
        end
        if (strobe) begin
          dat <= ad;
          got <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bus_cycle_monitor_chk.sv
module bus_cycle_monitor_chk #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          run,
  input logic          rec_valid,
  input logic [2:0]    rec_kind,
  input logic [15:0]   rec_addr,
  input logic [7:0]    rec_data,
  input logic [TW-1:0] rec_tcount,
  input logic          rec_len_err,
  input logic          rec_port_mismatch,
  input logic          rec_no_data
);

  assert_record_on_ale_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !$past(ale) && run) |=> rec_valid);

  assert_idle_no_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind == 3'd6) |-> rec_addr == 16'h0000);

  assert_no_data_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_no_data) |-> rec_data == 8'h00);

  assert_mismatch_only_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_port_mismatch) |-> (rec_kind == 3'd3 || rec_kind == 3'd4));

  assert_three_state_rw_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind >= 3'd1 && rec_kind <= 3'd4 && rec_tcount == TW'(3)) |-> !rec_len_err);

  assert_undefined_always_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind == 3'd7) |-> rec_len_err);

  assert_nonzero_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_tcount != '0);

endmodule

bind bus_cycle_monitor bus_cycle_monitor_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .run(run),
  .rec_valid(rec_valid), .rec_kind(rec_kind), .rec_addr(rec_addr), .rec_data(rec_data),
  .rec_tcount(rec_tcount), .rec_len_err(rec_len_err),
  .rec_port_mismatch(rec_port_mismatch), .rec_no_data(rec_no_data)
);

// File: tb/tb_bus_cycle_monitor.sv
`timescale 1ns/1ps
module tb_bus_cycle_monitor;
  localparam int TW = 4;
  localparam int TMAX = 15;

  logic clk = 0, rst_n = 0, ale = 0, io_m = 0, rd_n = 1, wr_n = 1, inta_n = 1;
  logic [7:0] ad = 0, a_hi = 0;
  logic [1:0] st = 0;
  logic rec_valid, rec_len_err, rec_port_mismatch, rec_no_data;
  logic [2:0] rec_kind;
  logic [15:0] rec_addr;
  logic [7:0] rec_data;
  logic [TW-1:0] rec_tcount;

  bus_cycle_monitor #(.TW(TW)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit started = 0;

  // behavioural reference: samples of the current cycle kept in queues
  bit q_ale[$]; bit q_stb[$]; logic [7:0] q_ad[$]; logic [7:0] q_hi[$]; logic [2:0] q_st[$];
  bit m_prev_ale, m_last_inta;
  bit e_valid, e_len, e_mis, e_nod;
  int e_kind, e_addr, e_data, e_t;

  function automatic int kind_of(logic [2:0] s);
    case (s)
      3'b011: return 0; 3'b010: return 1; 3'b001: return 2; 3'b110: return 3;
      3'b101: return 4; 3'b111: return 5; 3'b000: return 6; default: return 7;
    endcase
  endfunction

  task automatic emit();
    int n = q_st.size();
    int k = kind_of(q_st[0]);
    int a = 0, d = 0;
    bit g = 0, ok;
    for (int i = 0; i < n; i++) begin
      if (q_ale[i]) a = {q_hi[i], q_ad[i]};
      if (q_stb[i]) begin d = q_ad[i]; g = 1; end
    end
    e_t = (n > TMAX) ? TMAX : n;
    case (k)
      0: ok = (e_t == 4 || e_t == 6);
      1, 2, 3, 4: ok = (e_t == 3);
      5: ok = m_last_inta ? (e_t == 3) : (e_t == 6);
      6: ok = (e_t == 6);
      default: ok = 0;
    endcase
    m_last_inta = (k == 5);
    e_valid = 1; e_kind = k; e_addr = a; e_data = g ? d : 0; e_nod = !g; e_len = !ok;
    e_mis = (k == 3 || k == 4) && (a[15:8] != a[7:0]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ale.delete(); q_stb.delete(); q_ad.delete(); q_hi.delete(); q_st.delete();
      m_prev_ale = 0; m_last_inta = 0; e_valid = 0;
    end else begin
      logic [2:0] s, cs;
      bit beg;
      s = {io_m, st};
      cs = (q_st.size() == 0) ? 3'b000 : q_st[0];
      beg = (ale && !m_prev_ale) || (!ale && s != cs);
      e_valid = 0;
      if (beg) begin
        if (q_st.size() > 0) emit();
        q_ale.delete(); q_stb.delete(); q_ad.delete(); q_hi.delete(); q_st.delete();
      end
      if (beg || q_st.size() > 0) begin
        q_ale.push_back(ale); q_stb.push_back(!rd_n || !wr_n || !inta_n);
        q_ad.push_back(ad); q_hi.push_back(a_hi); q_st.push_back(s);
      end
      m_prev_ale = ale;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R6 valid", rec_valid, e_valid);
      if (e_valid && rec_valid) begin
        chk(e_kind == 6 ? "R7 idle address" : "R2 address", rec_addr, e_addr);
        chk("R3 kind", rec_kind, e_kind);
        chk(e_t == TMAX ? "R12 saturated length" : "R4 length", rec_tcount, e_t);
        chk("R5 data", rec_data, e_data);
        chk(e_kind == 5 ? "R9 acknowledge length" : "R8 length error", rec_len_err, e_len);
        chk("R10 port mismatch", rec_port_mismatch, e_mis);
        chk("R11 no data", rec_no_data, e_nod);
      end
    end
  end

  task automatic drive(bit a, logic [7:0] d, logic [7:0] h, logic [2:0] s, bit r, bit w, bit i);
    @(negedge clk);
    ale = a; ad = d; a_hi = h; {io_m, st} = s; rd_n = r; wr_n = w; inta_n = i;
  endtask

  // stb: 0 none, 1 read, 2 write, 3 acknowledge
  task automatic mc(logic [2:0] s, logic [15:0] addr, logic [7:0] data, int nt, int stb);
    drive(1, addr[7:0], addr[15:8], s, 1, 1, 1);
    for (int t = 2; t <= nt; t++) begin
      bit on = (t <= 3);
      drive(0, on ? data : ~data, addr[15:8], s,
            !(on && stb == 1), !(on && stb == 2), !(on && stb == 3));
    end
  endtask

  task automatic idle(int nt);
    for (int t = 0; t < nt; t++) drive(0, 8'(t * 7), 8'h5A, 3'b000, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", rec_valid, 0);
    chk("R1 reset address", rec_addr, 0);
    chk("R1 reset length", rec_tcount, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", rec_valid, 0);
    started = 1;
    mc(3'b011, 16'h4045, 8'h32, 4, 1);
    mc(3'b010, 16'h4046, 8'h50, 3, 1);
    mc(3'b010, 16'h4047, 8'h20, 3, 1);
    mc(3'b001, 16'h2050, 8'hA5, 3, 2);
    mc(3'b011, 16'h1000, 8'h09, 4, 1);
    idle(6);
    mc(3'b011, 16'h1001, 8'h23, 6, 1);
    mc(3'b110, 16'h3C3C, 8'h7E, 3, 1);
    mc(3'b101, 16'h3C3D, 8'h11, 3, 2);
    mc(3'b111, 16'h2222, 8'hCD, 6, 3);
    mc(3'b111, 16'h2223, 8'h34, 3, 3);
    mc(3'b111, 16'h2224, 8'h12, 3, 3);
    mc(3'b001, 16'h3FFF, 8'h40, 3, 2);
    mc(3'b001, 16'h3FFE, 8'h41, 3, 2);
    mc(3'b111, 16'h0038, 8'hFF, 3, 3);
    mc(3'b010, 16'h8000, 8'h66, 4, 1);
    mc(3'b010, 16'h8001, 8'h77, 3, 0);
    idle(20);
    mc(3'b100, 16'h1234, 8'h99, 3, 0);
    mc(3'b011, 16'h0000, 8'h00, 4, 1);
    drive(1, 8'h01, 8'h00, 3'b011, 1, 1, 1);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule